// File: doc/BRIEF.md
# Circular Capture Buffer Controller

This block takes a stream of 32-bit log words, each qualified by a valid strobe, and turns them into word writes into a memory window. Software sets the window with a base address and an end address. Each accepted word goes to the current write pointer, and the pointer then moves on by one word. In continuous mode the pointer wraps back to base once the window is used up. In one-shot mode capture halts once the last word of the window is written. The block also compares the write pointer against a read pointer that software owns, and flags when the writer catches up with it.

The memory side presents an address, the data and a write strobe, and accepts a stall input. While the memory stalls, the pending write is held. A word that arrives while the single pending slot is still blocked is dropped, and that loss is recorded in its own status bit. Software controls and observes the block through six 32-bit registers on a Wishbone-style slave port.

The window is half-open: writes land at base, base+4 and so on up to end-4. Status bits are sticky and are cleared only when capture is armed again.

Top module: `capture_ring_ctrl`

## Requirements
- R1: After reset every register reads 0 and `mem_wr` is low.
- R2: Registers sit at byte offsets 0x00 control, 0x04 base, 0x08 end, 0x0C status, 0x10 current pointer and 0x14 read pointer. Base, end and read pointer read back the full 32-bit value written. Control keeps only bit 0 (enable) and bit 1 (continuous); its other bits read 0.
- R3: A bus access is acknowledged in the cycle after the strobe is sampled, with read data valid alongside the acknowledge. Writes to status (0x0C) and current pointer (0x10) have no effect. Offsets with a nonzero byte-lane part, and offsets 0x18 and above, read 0.
- R4: A control write that sets enable while enable is 0 arms capture. Arming loads the current pointer from base and clears all status bits.
- R5: While armed, each accepted log word is issued on `mem_addr`/`mem_data` with `mem_wr` high, at the pointer value it arrived at. The pointer then advances by 4.
- R6: In continuous mode (control bit 1 = 1), when the advanced pointer would reach or pass end, the pointer returns to base and status bit 1 (wrapped) is set.
- R7: In one-shot mode (control bit 1 = 0), the word written at end-4 is the last one. Later words are ignored, and the current pointer reads end.
- R8: Status bit 3 (overflow) is set when an advance makes the current pointer equal to the read pointer.
- R9: While `mem_stall` is high with a write pending, `mem_wr`, `mem_addr` and `mem_data` stay unchanged. The write completes on a cycle where the stall is low.
- R10: A log word that arrives while a pending write is stalled is dropped. It sets status bit 2 (memory stall) and does not advance the pointer.
- R11: Status bit 0 (triggered) is set when the first word after arming completes its memory write. A word held pending by a stall does not set it.
- R12: While enable is 0, log words have no effect. Status bits stay set until the next arm, including across a control write that keeps enable at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| log_valid | input | 1 | Log word strobe |
| log_data | input | 32 | Log word |
| wb_cyc | input | 1 | Bus cycle |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_addr | input | 8 | Bus byte offset |
| wb_wdata | input | 32 | Bus write data |
| wb_ack | output | 1 | Bus acknowledge |
| wb_rdata | output | 32 | Bus read data |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | 32 | Memory byte address |
| mem_data | output | 32 | Memory write data |
| mem_stall | input | 1 | Memory not accepting |

## Verification
The hardest state to reach is a lost word. Getting there needs a write already pending in the single output slot, with the stall still high, at the moment a second word arrives. The bench raises the stall first and then pushes one word, which fills the slot. It then pushes a second word, which is dropped. While the stall is held it reads status and the pointer, which shows that the loss was flagged, that the pointer did not move and that the trigger is still clear. It then releases the stall and confirms that exactly one write reaches memory. Wrap and overflow come from sweeping the window size, the read-pointer position and the word count, with the expected pointer and flags computed by modular arithmetic.

// File: rtl/capture_ring_ctrl.sv
module capture_ring_ctrl #(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int RA   = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          log_valid,
  input  logic [DW-1:0] log_data,
  input  logic          wb_cyc,
  input  logic          wb_stb,
  input  logic          wb_we,
  input  logic [RA-1:0] wb_addr,
  input  logic [31:0]   wb_wdata,
  output logic          wb_ack,
  output logic [31:0]   wb_rdata,
  output logic          mem_wr,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  input  logic          mem_stall
);
  localparam int IW = RA - 2;

  logic          en_q, cont_q, run_q, wr_q;
  logic [AW-1:0] base_q, end_q, rd_q, cur_q, maddr_q;
  logic [DW-1:0] mdata_q;
  logic [3:0]    sts_q;
  logic [31:0]   rmux;

  wire [IW-1:0] idx    = wb_addr[RA-1:2];
  wire          lane0  = (wb_addr[1:0] == 2'b00);
  wire          bus_go = wb_stb & wb_cyc & ~wb_ack;
  wire          bus_wr = bus_go & wb_we & lane0;
  wire          arm    = bus_wr && (idx == IW'(0)) && wb_wdata[0] && !en_q;
  wire          active = en_q & run_q;
  wire          free   = ~wr_q | ~mem_stall;
  wire          take   = log_valid & active & free;
  wire          drop   = log_valid & active & ~free;
  wire          done   = wr_q & ~mem_stall;
  wire [AW-1:0] inc    = cur_q + AW'(STEP);
  wire          at_end = (inc >= end_q);
  wire [AW-1:0] nxt    = (at_end && cont_q) ? base_q : inc;

  assign mem_wr   = wr_q;
  assign mem_addr = maddr_q;
  assign mem_data = mdata_q;

  always_comb begin
    rmux = '0;
    if (lane0)
      case (idx)
        IW'(0): rmux = {30'd0, cont_q, en_q};
        IW'(1): rmux = 32'(base_q);
        IW'(2): rmux = 32'(end_q);
        IW'(3): rmux = {28'd0, sts_q};
        IW'(4): rmux = 32'(cur_q);
        IW'(5): rmux = 32'(rd_q);
        default: rmux = '0;
      endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wb_ack <= 1'b0; wb_rdata <= '0;
      en_q <= 1'b0; cont_q <= 1'b0; run_q <= 1'b0; wr_q <= 1'b0;
      base_q <= '0; end_q <= '0; rd_q <= '0; cur_q <= '0;
      maddr_q <= '0; mdata_q <= '0; sts_q <= '0;
    end else begin
      wb_ack <= bus_go;
      if (bus_go) wb_rdata <= rmux;
      if (bus_wr)
        case (idx)
          IW'(0): begin en_q <= wb_wdata[0]; cont_q <= wb_wdata[1]; end
          IW'(1): base_q <= AW'(wb_wdata);
          IW'(2): end_q  <= AW'(wb_wdata);
          IW'(5): rd_q   <= AW'(wb_wdata);
          default: ;
        endcase
      if (arm) begin
        cur_q <= base_q;
        sts_q <= '0;
        run_q <= 1'b1;
      end else begin
        if (take) begin
          cur_q <= nxt;
          if (at_end && cont_q)  sts_q[1] <= 1'b1;
          if (at_end && !cont_q) run_q <= 1'b0;
          if (nxt == rd_q)       sts_q[3] <= 1'b1;
        end
        if (drop) sts_q[2] <= 1'b1;
        if (done) sts_q[0] <= 1'b1;
      end
      if (free) begin
        wr_q <= take;
        if (take) begin
          maddr_q <= cur_q;
          mdata_q <= log_data;
        end
      end
    end
  end

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    mem_wr && mem_stall |=> mem_wr && $stable(mem_addr) && $stable(mem_data));

  a_r10_drop: assert property (@(posedge clk) disable iff (rst)
    log_valid && en_q && run_q && mem_wr && mem_stall |=> sts_q[2]);

  a_r12_sticky: assert property (@(posedge clk) disable iff (rst)
    !arm |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    take && cont_q && at_end |=> cur_q == $past(base_q));

  a_r5_addr: assert property (@(posedge clk) disable iff (rst)
    take |=> mem_wr && mem_addr == $past(cur_q));

  a_r4_arm: assert property (@(posedge clk) disable iff (rst)
    arm |=> cur_q == $past(base_q) && sts_q == 4'd0);
endmodule

// File: tb/capture_ring_ctrl_test.sv
`timescale 1ns/1ps
module capture_ring_ctrl_test;
  logic clk = 1'b0, rst = 1'b1;
  logic log_valid = 1'b0, wb_cyc = 1'b0, wb_stb = 1'b0, wb_we = 1'b0, mem_stall = 1'b0;
  logic [31:0] log_data = '0, wb_wdata = '0;
  logic [7:0]  wb_addr = '0;
  logic        wb_ack, mem_wr;
  logic [31:0] wb_rdata, mem_addr, mem_data;

  capture_ring_ctrl uut (
    .clk(clk), .rst(rst), .log_valid(log_valid), .log_data(log_data),
    .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we), .wb_addr(wb_addr),
    .wb_wdata(wb_wdata), .wb_ack(wb_ack), .wb_rdata(wb_rdata),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data), .mem_stall(mem_stall));

  always #10 clk = ~clk;

  int total = 0, bad = 0, wcnt = 0;
  logic [31:0] waddr [64];
  logic [31:0] wdat  [64];
  localparam logic [31:0] BASE = 32'h100;

  always @(posedge clk)
    if (mem_wr && !mem_stall) begin
      if (wcnt < 64) begin waddr[wcnt] = mem_addr; wdat[wcnt] = mem_data; end
      wcnt = wcnt + 1;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic we, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(negedge clk);
    chk("R3 ack idle", {31'd0, wb_ack}, 0);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_addr = a; wb_wdata = d;
    @(posedge clk); #1;
    wb_cyc = 0; wb_stb = 0; wb_we = 0;
    @(negedge clk);
    chk("R3 ack", {31'd0, wb_ack}, 1);
    q = wb_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic rdchk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] q;
    bus(1'b0, a, 32'd0, q);
    chk(tag, q, exp);
  endtask

  task automatic push(input logic [31:0] d);
    @(negedge clk);
    log_valid = 1; log_data = d;
    @(posedge clk); #1;
    log_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(input logic [31:0] cfg);
    wr(8'h00, 32'd0);
    wcnt = 0;
    wr(8'h00, cfg);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok;
    logic [31:0] ex;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 mem_wr", {31'd0, mem_wr}, 0);
    for (int i = 0; i < 6; i++) rdchk("R1 reg", 8'(i * 4), 0);

    wr(8'h04, 32'h12345678); rdchk("R2 base", 8'h04, 32'h12345678);
    wr(8'h08, 32'hCAFEF00C); rdchk("R2 end", 8'h08, 32'hCAFEF00C);
    wr(8'h14, 32'h89ABCDEF); rdchk("R2 read", 8'h14, 32'h89ABCDEF);
    wr(8'h00, 32'hFFFFFFFE); rdchk("R2 ctrl bits", 8'h00, 32'h2);
    wr(8'h00, 32'd0);
    wr(8'h0C, 32'hF);        rdchk("R3 status ro", 8'h0C, 0);
    wr(8'h10, 32'hABCD);     rdchk("R3 current ro", 8'h10, 0);
    wr(8'h18, 32'hFFFF);     rdchk("R3 unmapped 18", 8'h18, 0);
    rdchk("R3 unmapped FC", 8'hFC, 0);
    rdchk("R3 lane offset", 8'h05, 0);

    wr(8'h04, BASE);
    wr(8'h14, 32'h200);
    for (int n = 1; n <= 6; n++) begin
      wr(8'h08, BASE + 32'(4 * n));
      arm(32'h1);
      rdchk("R4 arm current", 8'h10, BASE);
      rdchk("R11 trig clear after arm", 8'h0C, 0);
      for (int j = 0; j < n + 2; j++) push(32'h5A000000 | 32'(n << 8) | 32'(j));
      idle(3);
      chk("R7 write count", 32'(wcnt), 32'(n));
      ok = 1;
      for (int j = 0; j < n; j++)
        if (waddr[j] !== BASE + 32'(4 * j) || wdat[j] !== (32'h5A000000 | 32'(n << 8) | 32'(j))) ok = 0;
      chk("R5 one-shot addr/data", {31'd0, ok}, 1);
      rdchk("R7 current at end", 8'h10, BASE + 32'(4 * n));
      rdchk("R11 status one-shot", 8'h0C, 32'h1);
    end

    for (int n = 1; n <= 4; n++)
      for (int r = 0; r < n; r++)
        for (int k = 1; k <= 2 * n + 1; k++) begin
          wr(8'h08, BASE + 32'(4 * n));
          wr(8'h14, BASE + 32'(4 * r));
          arm(32'h3);
          for (int j = 0; j < k; j++) push(32'hC0000000 | 32'(k << 16) | 32'(r << 8) | 32'(j));
          idle(3);
          chk("R5 cont count", 32'(wcnt), 32'(k));
          ok = 1;
          for (int j = 0; j < k; j++)
            if (waddr[j] !== BASE + 32'(4 * (j % n)) ||
                wdat[j] !== (32'hC0000000 | 32'(k << 16) | 32'(r << 8) | 32'(j))) ok = 0;
          chk("R6 cont addr/data", {31'd0, ok}, 1);
          rdchk("R6 cont current", 8'h10, BASE + 32'(4 * (k % n)));
          ex = 32'h1;
          if (k >= n) ex[1] = 1'b1;
          if ((r == 0 && k >= n) || (r != 0 && k >= r)) ex[3] = 1'b1;
          rdchk("R8 cont status", 8'h0C, ex);
        end

    wr(8'h08, BASE + 32'h10);
    wr(8'h14, 32'h200);
    arm(32'h1);
    @(negedge clk); mem_stall = 1;
    push(32'h11111111);
    @(negedge clk);
    chk("R9 pending wr", {31'd0, mem_wr}, 1);
    chk("R9 pending addr", mem_addr, BASE);
    chk("R9 pending data", mem_data, 32'h11111111);
    rdchk("R11 trig not set while stalled", 8'h0C, 0);
    push(32'h22222222);
    idle(2);
    chk("R9 held addr", mem_addr, BASE);
    chk("R9 held data", mem_data, 32'h11111111);
    chk("R9 no write during stall", 32'(wcnt), 0);
    rdchk("R10 stall flag", 8'h0C, 32'h4);
    rdchk("R10 pointer not advanced", 8'h10, BASE + 32'h4);
    @(negedge clk); mem_stall = 0;
    idle(2);
    chk("R9 one write after release", 32'(wcnt), 1);
    chk("R9 written addr", waddr[0], BASE);
    chk("R10 survivor data", wdat[0], 32'h11111111);
    chk("R9 strobe drops", {31'd0, mem_wr}, 0);
    rdchk("R11 trig after write", 8'h0C, 32'h5);

    wr(8'h00, 32'h1);
    rdchk("R12 sticky no rearm", 8'h0C, 32'h5);
    wr(8'h00, 32'h0);
    push(32'h33333333);
    idle(3);
    chk("R12 disabled no write", 32'(wcnt), 1);
    rdchk("R12 disabled current", 8'h10, BASE + 32'h4);
    rdchk("R12 disabled status", 8'h0C, 32'h5);
    wr(8'h00, 32'h1);
    rdchk("R4 rearm status", 8'h0C, 0);
    rdchk("R4 rearm current", 8'h10, BASE);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule